// File: doc/BRIEF.md
# Register-Mapped I2C Master Controller

This block is an I2C master controller that software drives through five 8-bit registers on a simple register port. It raises one interrupt line. Waveform generation on SCL and SDA is left to a separate byte engine. The controller talks to that engine over an abstract transaction port. Each transaction is a one-cycle request carrying an opcode and a byte. The engine later returns a done strobe, which carries a not-acknowledge flag and, for reads, the received byte.

Software selects a master mode and enables the output stage. It then loads the slave address and direction into the data register and writes the status register to issue a start. After every byte the controller sets a sticky pending bit and raises the interrupt. The next byte moves only after software has done two things: serviced the data register by reading or writing it, and cleared the pending bit. This pacing stands in for clock stretching on the wire. While a transaction is outstanding, the register port drops its ready output, so at most one transaction is ever in flight.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset, the registers read as follows: control 0x00, status 0x00, own address 0xFF, data 0xFF, line control 0x00. The interrupt output is low.
- R2: The registers sit at byte offsets 0x00 (control), 0x04 (status), 0x08 (own address), 0x0C (data) and 0x10 (line control). Any other offset, misaligned ones included, reads 0, and a write to it has no effect. Line control is plain storage.
- R3: Control bit 4 is the pending flag, and the interrupt output equals it. Only hardware sets it, and only when control bit 5 (interrupt enable) is 1. Writing 1 to bit 4 while it is 0 leaves it at 0.
- R4: Writing control with bit 4 = 0 while pending clears pending and drops the interrupt. If the same write has bit 5 = 0, status bit 5 (busy) is cleared too.
- R5: Status bits [7:6] hold the mode: 2 is master receive, 3 is master transmit, and bit 7 = 0 is slave. Software cannot set busy by writing it. A status write in slave mode issues no transaction.
- R6: A status write with bit 4 (output enable) = 0 clears busy and pending, drops the interrupt, marks the data register serviced and issues no transaction.
- R7: In a master mode, a status write with bit 5 = 1 does the following: it clears bit 0, sets busy and issues a start with the data register as the address byte. A nack with control bit 7 (ack handling) = 1 sets status bit 0. Pending is then raised.
- R8: In master receive, a start that ends without a flagged nack is followed at once by a read. The received byte is loaded into the data register before pending is raised.
- R9: In a master mode, a status write with bit 5 = 0 issues a stop and marks the data register serviced. Busy is cleared only if nothing is pending.
- R10: The own-address register accepts writes only while output enable is 0. The data register accepts writes only while output enable is 1.
- R11: A data write marks the register serviced; in transmit mode it starts a write transaction at once if busy is set and nothing is pending. A data read does the same with a read transaction in receive mode. Each write or read transaction clears status bit 0. A finished write sets status bit 0 on a nack when ack handling is on.
- R12: If pending is cleared while busy and interrupts are enabled, the result depends on the data register. If it was serviced, the next transfer for the mode starts. If not, pending is set again.
- R13: The transaction port uses opcodes 0 start, 1 write, 2 read and 3 stop. A request is high for exactly one cycle, and register ready stays low until the transaction and any chained read are done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_sel is high |
| reg_ready | output | 1 | Access is accepted on a clock edge where reg_sel and reg_ready are both high |
| irq | output | 1 | Interrupt, equal to the pending flag |
| txn_req | output | 1 | One-cycle transaction request |
| txn_op | output | 2 | Transaction opcode |
| txn_byte | output | 8 | Address byte or data byte for the transaction |
| txn_done | input | 1 | Transaction finished strobe |
| txn_nack | input | 1 | Target did not acknowledge |
| txn_rdata | input | 8 | Byte received by a read transaction |

## Verification
The bench targets the handshake corners of this block. The first is clearing pending before the data register has been serviced: a design that ignores the serviced flag would send a stale byte instead of re-raising the interrupt. The second is a stop issued while pending, where a design that drops busy early loses the current byte. The third is the start in receive mode, where a missing chained read leaves the data register holding the address. The bench also checks that a nack without ack handling never sets status bit 0, and that output-disable and slave-mode writes put nothing on the transaction port.

// File: rtl/i2c_host_pkg.sv
// Package i2c_host_pkg
// Shared constants and types for the I2C master controller: register width,
// the bit positions of the control and status fields, mode codes, register
// indices and the transaction opcode type.
// Assumes 8-bit registers laid out on a 4-byte stride.
package i2c_host_pkg;

    localparam int REG_W = 8;

    // Control register bit positions
    localparam int B_ACKEN = 7;
    localparam int B_IEN   = 5;
    localparam int B_PEND  = 4;

    // Status register bit positions
    localparam int B_MST   = 7;
    localparam int B_BUSY  = 5;
    localparam int B_OE    = 4;
    localparam int B_LAST  = 0;

    localparam logic [1:0] MODE_MRX = 2'd2;
    localparam logic [1:0] MODE_MTX = 2'd3;

    // Register indices (offset / 4)
    localparam int IDX_CON  = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_OWN  = 2;
    localparam int IDX_DS   = 3;
    localparam int IDX_LC   = 4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } i2c_op_e;

endpackage

// File: rtl/i2c_host_decode.sv
// Module i2c_host_decode
// Turns a byte offset into a one-hot register select.
// Register i sits at byte offset 4*i. Offsets outside the window, and offsets
// that are not multiples of 4, select nothing.
// Purely combinational.
module i2c_host_decode #(
    parameter int ADDR_W   = 5,
    parameter int NUM_REGS = 5
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] hit
);

    localparam int STRIDE = 4;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_hit
        // compare the offset against this register's slot
        assign hit[gi] = (addr == ADDR_W'(gi * STRIDE));
    end

endmodule

// File: rtl/i2c_host_txn.sv
// Module i2c_host_txn
// Transaction sequencer. It accepts one command while idle and drives a
// one-cycle request on the transaction port. It then waits for the done
// strobe and reports the result with a one-cycle fin pulse.
// Assumes that done never arrives in the same cycle as the request it answers.
module i2c_host_txn
    import i2c_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  i2c_op_e          cmd_op,
    input  logic [REG_W-1:0] cmd_byte,
    output logic             idle,
    output logic             fin,
    output i2c_op_e          fin_op,
    output logic             fin_nack,
    output logic [REG_W-1:0] fin_data,
    output logic             txn_req,
    output i2c_op_e          txn_op,
    output logic [REG_W-1:0] txn_byte,
    input  logic             txn_done,
    input  logic             txn_nack,
    input  logic [REG_W-1:0] txn_rdata
);

    logic             busy_q;
    logic             req_q;
    i2c_op_e          op_q;
    logic [REG_W-1:0] byte_q;

    // track the one outstanding transaction and the single request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            req_q  <= 1'b0;
            op_q   <= OP_STOP;
            byte_q <= '0;
        end else begin
            req_q <= 1'b0;
            if (!busy_q && cmd_valid) begin
                busy_q <= 1'b1;
                req_q  <= 1'b1;
                op_q   <= cmd_op;
                byte_q <= cmd_byte;
            end else if (fin) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign idle     = !busy_q;
    assign fin      = busy_q && !req_q && txn_done;
    assign fin_op   = op_q;
    assign fin_nack = txn_nack;
    assign fin_data = txn_rdata;
    assign txn_req  = req_q;
    assign txn_op   = op_q;
    assign txn_byte = byte_q;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_req |=> !txn_req);                                   // R13
    AST_CMD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !idle) |-> fin);                           // R13

endmodule

// File: rtl/i2c_host_ctrl.sv
// Module i2c_host_ctrl (top)
// Register-mapped I2C master controller. It holds five byte registers,
// drives the interrupt from the sticky pending bit, and launches start,
// write, read and stop transactions through i2c_host_txn. A start in
// receive mode is followed by a chained read one cycle after the start ends.
// Register accesses stall (reg_ready low) while a transaction is in flight.
module i2c_host_ctrl
    import i2c_host_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int NUM_REGS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              reg_ready,
    output logic              irq,
    output logic              txn_req,
    output logic [1:0]        txn_op,
    output logic [7:0]        txn_byte,
    input  logic              txn_done,
    input  logic              txn_nack,
    input  logic [7:0]        txn_rdata
);

    localparam logic [REG_W-1:0] RST_ONES = '1;

    logic [NUM_REGS-1:0] hit;
    logic [REG_W-1:0] con_q, stat_q, own_q, ds_q, lc_q;
    logic [REG_W-1:0] con_n, stat_n, own_n, ds_n, lc_n;
    logic             srv_q, srv_n, chain_q, chain_n;
    logic             launch, raise;
    i2c_op_e          launch_op;
    logic [REG_W-1:0] launch_byte;
    logic             seq_idle, fin, fin_nack;
    i2c_op_e          fin_op, seq_op;
    logic [REG_W-1:0] fin_data;
    logic             wr_acc, rd_acc, pend, busy, oe;
    logic [1:0]       mode;

    i2c_host_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    i2c_host_txn u_txn (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (launch),
        .cmd_op    (launch_op),
        .cmd_byte  (launch_byte),
        .idle      (seq_idle),
        .fin       (fin),
        .fin_op    (fin_op),
        .fin_nack  (fin_nack),
        .fin_data  (fin_data),
        .txn_req   (txn_req),
        .txn_op    (seq_op),
        .txn_byte  (txn_byte),
        .txn_done  (txn_done),
        .txn_nack  (txn_nack),
        .txn_rdata (txn_rdata)
    );

    assign txn_op    = seq_op;
    assign reg_ready = seq_idle && !chain_q;
    assign wr_acc    = reg_sel && reg_ready && reg_wr;
    assign rd_acc    = reg_sel && reg_ready && !reg_wr;
    assign pend      = con_q[B_PEND];
    assign busy      = stat_q[B_BUSY];
    assign oe        = stat_q[B_OE];
    assign mode      = stat_q[7:6];
    assign irq       = con_q[B_PEND];

    // select the read value for the addressed register, 0 when unmapped
    always_comb begin
        reg_rdata = '0;
        if (hit[IDX_CON])  reg_rdata = con_q;
        if (hit[IDX_STAT]) reg_rdata = stat_q;
        if (hit[IDX_OWN])  reg_rdata = own_q;
        if (hit[IDX_DS])   reg_rdata = ds_q;
        if (hit[IDX_LC])   reg_rdata = lc_q;
    end

    // work out the register updates and any transaction to launch this cycle
    always_comb begin
        con_n = con_q;  stat_n = stat_q; own_n = own_q;
        ds_n  = ds_q;   lc_n   = lc_q;   srv_n = srv_q;
        chain_n = 1'b0; raise = 1'b0;
        launch = 1'b0;  launch_op = OP_WRITE; launch_byte = ds_q;

        if (chain_q) begin
            launch    = 1'b1;
            launch_op = OP_READ;
        end

        if (fin) begin
            case (fin_op)
                OP_START: begin
                    if (fin_nack && con_q[B_ACKEN]) begin
                        stat_n[B_LAST] = 1'b1;
                        raise = 1'b1;
                    end else if (mode == MODE_MRX) begin
                        chain_n = 1'b1;
                    end else begin
                        raise = 1'b1;
                    end
                end
                OP_WRITE: begin
                    stat_n[B_LAST] = fin_nack && con_q[B_ACKEN];
                    raise = 1'b1;
                end
                OP_READ: begin
                    ds_n  = fin_data;
                    raise = 1'b1;
                end
                default: ;
            endcase
            if (raise && con_q[B_IEN]) con_n[B_PEND] = 1'b1;
        end

        if (wr_acc && hit[IDX_CON]) begin
            con_n = reg_wdata;
            con_n[B_PEND] = pend;
            if (pend && !reg_wdata[B_PEND]) begin
                con_n[B_PEND] = 1'b0;
                if (!reg_wdata[B_IEN]) begin
                    stat_n[B_BUSY] = 1'b0;
                end else if (busy) begin
                    if (!srv_q) begin
                        con_n[B_PEND] = 1'b1;
                    end else if (mode == MODE_MTX) begin
                        launch = 1'b1; launch_op = OP_WRITE;
                    end else if (mode == MODE_MRX) begin
                        launch = 1'b1; launch_op = OP_READ;
                    end
                end
            end
        end

        if (wr_acc && hit[IDX_STAT]) begin
            stat_n = reg_wdata;
            stat_n[B_BUSY] = busy;
            if (!reg_wdata[B_OE]) begin
                stat_n[B_BUSY] = 1'b0;
                con_n[B_PEND]  = 1'b0;
                srv_n = 1'b1;
            end else if (reg_wdata[B_MST]) begin
                launch = 1'b1;
                if (reg_wdata[B_BUSY]) begin
                    stat_n[B_LAST] = 1'b0;
                    stat_n[B_BUSY] = 1'b1;
                    srv_n     = 1'b0;
                    launch_op = OP_START;
                end else begin
                    if (!pend) stat_n[B_BUSY] = 1'b0;
                    srv_n     = 1'b1;
                    launch_op = OP_STOP;
                end
            end
        end

        if (wr_acc && hit[IDX_OWN] && !oe) own_n = reg_wdata;
        if (wr_acc && hit[IDX_LC]) lc_n = reg_wdata;

        if (wr_acc && hit[IDX_DS] && oe) begin
            ds_n  = reg_wdata;
            srv_n = 1'b1;
            if (mode == MODE_MTX && busy && !pend) begin
                launch = 1'b1; launch_op = OP_WRITE; launch_byte = reg_wdata;
            end
        end

        if (rd_acc && hit[IDX_DS]) begin
            srv_n = 1'b1;
            if (mode == MODE_MRX && busy && !pend) begin
                launch = 1'b1; launch_op = OP_READ;
            end
        end

        if (launch && (launch_op == OP_WRITE || launch_op == OP_READ)) begin
            stat_n[B_LAST] = 1'b0;
            srv_n = 1'b0;
        end
    end

    // register state with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            con_q   <= '0;
            stat_q  <= '0;
            own_q   <= RST_ONES;
            ds_q    <= RST_ONES;
            lc_q    <= '0;
            srv_q   <= 1'b1;
            chain_q <= 1'b0;
        end else begin
            con_q   <= con_n;
            stat_q  <= stat_n;
            own_q   <= own_n;
            ds_q    <= ds_n;
            lc_q    <= lc_n;
            srv_q   <= srv_n;
            chain_q <= chain_n;
        end
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> con_q[B_IEN]);                                  // R3
    AST_SW_NO_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit[IDX_CON] && !pend) |=> !irq);                   // R3
    AST_OE_OFF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[B_OE] |-> !stat_q[B_BUSY]);                            // R6
    AST_OWN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit[IDX_OWN] && oe) |=> $stable(own_q));            // R10
    AST_DS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit[IDX_DS] && !oe) |=> $stable(ds_q));             // R10
    AST_STALL_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        txn_req |-> !reg_ready);                                       // R13

endmodule

// File: tb/tb_i2c_host_ctrl.sv
`timescale 1ns/1ps
// Testbench for i2c_host_ctrl: directed corner cases, then seeded random
// transmit and receive transfers against expected values from bench functions.
module tb_i2c_host_ctrl;

    localparam logic [4:0] A_CON = 5'h00, A_STAT = 5'h04, A_OWN = 5'h08,
                           A_DS = 5'h0C, A_LC = 5'h10;
    localparam logic [1:0] O_START = 2'd0, O_WRITE = 2'd1, O_READ = 2'd2, O_STOP = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_sel = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic reg_ready, irq, txn_req;
    logic [1:0] txn_op;
    logic [7:0] txn_byte;
    logic txn_done = 1'b0, txn_nack = 1'b0;
    logic [7:0] txn_rdata = '0;

    int checks = 0, fails = 0, n_txn = 0;
    logic [1:0] last_op = '0;
    logic [7:0] last_byte = '0;
    logic resp_nack = 1'b0;
    logic [7:0] resp_data = '0;
    bit summary_done = 0;

    i2c_host_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ready(reg_ready), .irq(irq), .txn_req(txn_req), .txn_op(txn_op),
        .txn_byte(txn_byte), .txn_done(txn_done), .txn_nack(txn_nack),
        .txn_rdata(txn_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    function automatic logic exp_last(input logic nk, input logic ack);
        return nk & ack;
    endfunction

    function automatic logic [7:0] con_val(input logic ack, input logic ien);
        return {ack, 1'b0, ien, 5'b0};
    endfunction

    // model of the byte engine: answer each request after a short delay
    initial begin
        forever begin
            @(negedge clk);
            if (txn_req) begin
                int d;
                n_txn++;
                last_op = txn_op;
                last_byte = txn_byte;
                d = 1 + int'($urandom % 3);
                @(negedge clk);
                check("R13 request width", {31'b0, txn_req}, 32'd0);
                repeat (d) @(negedge clk);
                txn_done = 1'b1; txn_nack = resp_nack; txn_rdata = resp_data;
                @(negedge clk);
                txn_done = 1'b0; txn_nack = 1'b0;
            end
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic wait_idle();
        while (!reg_ready) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wait_idle();
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        wait_idle();
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic wr_idle(input logic [4:0] a, input logic [7:0] d);
        bus_wr(a, d);
        wait_idle();
    endtask

    task automatic chk_reg(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        check(tag, {24'b0, v}, {24'b0, exp});
    endtask

    initial begin
        int cnt;
        logic [7:0] v;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        check("R1 irq", {31'b0, irq}, 32'd0);
        chk_reg("R1 control", A_CON, 8'h00);
        chk_reg("R1 status", A_STAT, 8'h00);
        chk_reg("R1 own", A_OWN, 8'hFF);
        chk_reg("R1 data", A_DS, 8'hFF);
        chk_reg("R1 linectl", A_LC, 8'h00);
        // R2 unmapped offsets and line control storage
        chk_reg("R2 unmapped 0x14", 5'h14, 8'h00);
        chk_reg("R2 misaligned 0x02", 5'h02, 8'h00);
        wr_idle(5'h18, 8'h55);
        chk_reg("R2 unmapped write", 5'h18, 8'h00);
        wr_idle(A_LC, 8'hC3);
        chk_reg("R2 linectl store", A_LC, 8'hC3);

        // R10 write gating by output enable
        wr_idle(A_OWN, 8'h5A);
        chk_reg("R10 own open", A_OWN, 8'h5A);
        wr_idle(A_DS, 8'h33);
        chk_reg("R10 data locked", A_DS, 8'hFF);
        wr_idle(A_CON, 8'hA0);
        cnt = n_txn;
        wr_idle(A_STAT, 8'hD0);
        check("R9 stop op", {30'b0, last_op}, {30'b0, O_STOP});
        wr_idle(A_OWN, 8'h11);
        chk_reg("R10 own locked", A_OWN, 8'h5A);
        cnt = n_txn;
        wr_idle(A_DS, 8'hA4);
        check("R11 no write when idle", n_txn, cnt);

        // R7 start with ack, R13 stall
        resp_nack = 1'b0;
        bus_wr(A_STAT, 8'hF0);
        check("R13 ready stalls", {31'b0, reg_ready}, 32'd0);
        wait_idle();
        check("R7 start op", {30'b0, last_op}, {30'b0, O_START});
        check("R7 start byte", {24'b0, last_byte}, 32'hA4);
        chk_reg("R7 status busy", A_STAT, 8'hF0);
        chk_reg("R7 pending", A_CON, 8'hB0);
        check("R7 irq", {31'b0, irq}, 32'd1);

        // R12 serviced then cleared -> write; R11 nack flag
        cnt = n_txn;
        wr_idle(A_DS, 8'h3C);
        check("R11 held while pending", n_txn, cnt);
        resp_nack = 1'b1;
        wr_idle(A_CON, 8'hA0);
        check("R12 write launched", {30'b0, last_op}, {30'b0, O_WRITE});
        check("R12 write byte", {24'b0, last_byte}, 32'h3C);
        chk_reg("R11 nack flag", A_STAT, 8'hF1);
        check("R12 irq again", {31'b0, irq}, 32'd1);

        // R12 cleared without servicing -> pending re-raised
        cnt = n_txn;
        wr_idle(A_CON, 8'hA0);
        check("R12 no transfer", n_txn, cnt);
        chk_reg("R12 pending back", A_CON, 8'hB0);
        resp_nack = 1'b0;
        wr_idle(A_DS, 8'h77);
        wr_idle(A_CON, 8'hA0);
        check("R11 write byte", {24'b0, last_byte}, 32'h77);
        chk_reg("R11 ack clears flag", A_STAT, 8'hF0);

        // R9 stop while pending keeps busy; R4 clear with enable 0
        wr_idle(A_STAT, 8'hD0);
        check("R9 stop op", {30'b0, last_op}, {30'b0, O_STOP});
        chk_reg("R9 busy kept", A_STAT, 8'hF0);
        cnt = n_txn;
        wr_idle(A_CON, 8'h80);
        chk_reg("R4 busy cleared", A_STAT, 8'hD0);
        check("R4 irq low", {31'b0, irq}, 32'd0);
        check("R4 no transfer", n_txn, cnt);

        // R9 stop with nothing pending; R8 receive start
        wr_idle(A_CON, 8'hA0);
        wr_idle(A_STAT, 8'h90);
        check("R9 stop op rx", {30'b0, last_op}, {30'b0, O_STOP});
        chk_reg("R9 idle status", A_STAT, 8'h90);
        wr_idle(A_DS, 8'hA5);
        resp_data = 8'h5E;
        cnt = n_txn;
        wr_idle(A_STAT, 8'hB0);
        check("R8 two transactions", n_txn, cnt + 2);
        check("R8 chained read", {30'b0, last_op}, {30'b0, O_READ});
        check("R8 irq", {31'b0, irq}, 32'd1);
        chk_reg("R8 received byte", A_DS, 8'h5E);
        resp_data = 8'h81;
        wr_idle(A_CON, 8'hA0);
        check("R12 read launched", {30'b0, last_op}, {30'b0, O_READ});
        chk_reg("R12 read data", A_DS, 8'h81);

        // R3 no pending with interrupts off; R11 read-driven receive
        wr_idle(A_CON, 8'h80);
        resp_data = 8'h11;
        wr_idle(A_STAT, 8'hB0);
        check("R3 irq stays low", {31'b0, irq}, 32'd0);
        resp_data = 8'h22;
        cnt = n_txn;
        bus_rd(A_DS, v);
        wait_idle();
        check("R11 read value", {24'b0, v}, 32'h11);
        check("R11 read launched", n_txn, cnt + 1);
        chk_reg("R11 next byte", A_DS, 8'h22);
        wait_idle();
        wr_idle(A_CON, 8'h90);
        chk_reg("R3 software set ignored", A_CON, 8'h80);
        check("R3 irq low", {31'b0, irq}, 32'd0);

        // R7 start nack with ack handling, R6 output disable
        wr_idle(A_STAT, 8'hD0);
        wr_idle(A_CON, 8'hA0);
        wr_idle(A_DS, 8'hA4);
        resp_nack = 1'b1;
        wr_idle(A_STAT, 8'hF0);
        chk_reg("R7 nack flag", A_STAT, 8'hF1);
        check("R7 irq on nack", {31'b0, irq}, 32'd1);
        cnt = n_txn;
        wr_idle(A_STAT, 8'h00);
        chk_reg("R6 status", A_STAT, 8'h00);
        chk_reg("R6 pending gone", A_CON, 8'hA0);
        check("R6 irq", {31'b0, irq}, 32'd0);
        check("R6 no transaction", n_txn, cnt);

        // R5 slave mode cannot set busy nor issue anything
        wr_idle(A_STAT, 8'h30);
        chk_reg("R5 busy not writable", A_STAT, 8'h10);
        check("R5 no transaction", n_txn, cnt);

        // seeded random transfers
        for (int it = 0; it < 40; it++) begin
            logic ack, nk;
            logic [7:0] a, d, cv, rdv;
            ack = 1'($urandom % 2);
            cv = con_val(ack, 1'b1);
            a = 8'($urandom);
            wr_idle(A_STAT, 8'h00);
            wr_idle(A_CON, cv);
            if (it % 2 == 0) begin
                wr_idle(A_STAT, 8'hD0);
                wr_idle(A_DS, a);
                nk = 1'($urandom % 2);
                resp_nack = nk;
                cnt = n_txn;
                wr_idle(A_STAT, 8'hF0);
                check("R7 random start", n_txn, cnt + 1);
                check("R7 random addr", {24'b0, last_byte}, {24'b0, a});
                chk_reg("R7 random status", A_STAT, 8'hF0 | {7'b0, exp_last(nk, ack)});
                for (int b = 0; b < 1 + int'($urandom % 3); b++) begin
                    d = 8'($urandom);
                    wr_idle(A_DS, d);
                    nk = 1'($urandom % 2);
                    resp_nack = nk;
                    wr_idle(A_CON, cv);
                    check("R11 random op", {30'b0, last_op}, {30'b0, O_WRITE});
                    check("R11 random byte", {24'b0, last_byte}, {24'b0, d});
                    chk_reg("R11 random status", A_STAT, 8'hF0 | {7'b0, exp_last(nk, ack)});
                    check("R12 random irq", {31'b0, irq}, 32'd1);
                end
            end else begin
                wr_idle(A_STAT, 8'h90);
                wr_idle(A_DS, a | 8'h01);
                nk = 1'($urandom % 2);
                rdv = 8'($urandom);
                resp_nack = nk; resp_data = rdv;
                cnt = n_txn;
                wr_idle(A_STAT, 8'hB0);
                check("R8 random irq", {31'b0, irq}, 32'd1);
                if (exp_last(nk, ack)) begin
                    check("R8 random no read", n_txn, cnt + 1);
                    chk_reg("R8 random status", A_STAT, 8'hB1);
                    chk_reg("R8 random data kept", A_DS, a | 8'h01);
                end else begin
                    check("R8 random read", n_txn, cnt + 2);
                    chk_reg("R8 random status", A_STAT, 8'hB0);
                    chk_reg("R8 random data", A_DS, rdv);
                end
            end
            wr_idle(A_STAT, 8'h00);
            check("R6 random irq", {31'b0, irq}, 32'd0);
        end

        summary();
        $finish;
    end

endmodule